// File: doc/BRIEF.md
# LED Blink Generator with Auto-Stop

This block drives a single LED with a programmable blink pattern. A power-of-two prescaler divides the input clock into a slow tick. Each tick advances a phase counter that wraps at a programmed period. The LED is lit for the early part of each period, for as many ticks as the duty value gives. Software sets up the blinker through four word-wide registers on a simple synchronous write bus. Reads are combinational.

An optional auto-stop mode lets the blinker run for a programmed number of complete periods and then switch itself off. When that happens a sticky flag is set, and the interrupt output carries it unless the mask bit is set. Any register write restarts the blink pattern from the start of a period. A host can therefore change the period, the duty or the count and get a clean, aligned pattern at once.

Top module: `led_blinker`

## Requirements
- R1: After reset, every register reads zero, `ledOut` is low and `irqOut` is low.
- R2: The word addresses are 0 (control, 7 bits), 1 (period, 12 bits), 2 (duty, 12 bits) and 3 (stop count, 16 bits). A read returns the stored value zero-extended to 16 bits, and bits written above a register's width are dropped.
- R3: Control bits [3:0] hold an exponent n. The phase advances once every 2^(13-n) clock cycles, so n=0 gives the slowest rate and n=13 advances the phase every cycle.
- R4: Exponent values 14 and 15 act as 13. The register still reads back the value that was written.
- R5: The phase counts 0, 1, …, P-1 and then returns to 0, where P is the period register. A period of 0 or 1 holds the phase at 0.
- R6: `ledOut` is high exactly when the enable bit is set and the phase is below the duty value. A duty of 0 keeps the LED dark, and a duty of at least P keeps it lit.
- R7: Control bit 4 is the run enable. While it is 0, `ledOut` is low.
- R8: A write to any register puts the prescaler and the phase back to zero at the write edge, and reloads the remaining-period count from the stop-count register. The first sample after the write shows phase 0.
- R9: With control bit 5 set, the blinker stops at the end of the N-th complete period, where N is the stop count. Stopping clears control bit 4, so the LED goes dark. A stop count of 0 behaves as 1.
- R10: An auto-stop sets a sticky flag, and `irqOut` equals that flag unless control bit 6 is set. Only a write to the control register clears the flag. Writes to the other registers leave it set.
- R11: With control bit 5 clear, the blinker keeps running past any number of periods, whatever the stop count holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Word address of the register |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for `busAddr`, combinational |
| ledOut | output | 1 | LED drive |
| irqOut | output | 1 | Auto-stop interrupt, level, after mask |

## Verification
The bench walks the phase across period and duty pairs that include duty 0, duty above the period, and periods of 0 and 1. A design that gets the wrap off by one, or compares with less-or-equal, shows a lit LED in a cycle where it should be dark. Auto-stop is tested on the exact cycle it fires, including a stop count of zero. A design that stops one period late, or treats a count of 0 as never stopping, keeps the LED lit one period too long. The test also checks that a write restarts the phase mid-period, that masking blocks the interrupt without blocking the stop, and that the flag survives writes to other registers. A design that forgets the restart, or clears the flag on any write, shows up here.

// File: rtl/blink_pkg.sv
package blink_pkg;
  // Width of the exponent field in the control register
  localparam int SEL_W = 4;

  // Control register bit positions
  localparam int RUN_BIT  = 4;
  localparam int STOP_BIT = 5;
  localparam int MASK_BIT = 6;
  localparam int CTRL_W   = 7;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_PERIOD = 2'd1,
    REG_DUTY   = 2'd2,
    REG_COUNT  = 2'd3
  } regIdx_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic restart;
    logic run;
  } dpStrobe_t;
endpackage

// File: rtl/blink_dp.sv
module blink_dp
  import blink_pkg::*;
#(
  parameter int PHASE_W = 12,
  parameter int MAX_EXP = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [SEL_W-1:0]   expSel,
  input  logic [PHASE_W-1:0] period,
  input  logic [PHASE_W-1:0] duty,
  output logic               wrapPulse,
  output logic               ledOut
);
  logic [MAX_EXP-1:0] preCnt;
  logic [MAX_EXP-1:0] tickMask;
  logic [PHASE_W-1:0] phase;
  logic [PHASE_W:0]   phaseNext;
  logic               tick;
  logic               lastPhase;

  // Tick every 2^(MAX_EXP-expSel) cycles; counter starts at zero on restart
  assign tickMask  = {MAX_EXP{1'b1}} >> expSel;
  assign tick      = strobe.run && ((preCnt & tickMask) == tickMask);
  assign phaseNext = {1'b0, phase} + {{PHASE_W{1'b0}}, 1'b1};
  assign lastPhase = phaseNext >= {1'b0, period};
  assign wrapPulse = tick && lastPhase;
  assign ledOut    = strobe.run && (phase < duty);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      phase  <= '0;
    end else if (strobe.restart) begin
      preCnt <= '0;
      phase  <= '0;
    end else if (strobe.run) begin
      preCnt <= preCnt + {{(MAX_EXP-1){1'b0}}, 1'b1};
      if (tick) phase <= lastPhase ? '0 : phaseNext[PHASE_W-1:0];
    end
  end

  // R5
  phase_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (period != '0) |-> (phase < period));

  // R8
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (phase == '0) && (preCnt == '0));

  // R7
  frozen_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run && !strobe.restart) |=> $stable(phase));
endmodule

// File: rtl/blink_ctrl.sv
module blink_ctrl
  import blink_pkg::*;
#(
  parameter int PHASE_W = 12,
  parameter int STOP_W  = 16,
  parameter int DATA_W  = 16,
  parameter int MAX_EXP = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         busAddr,
  input  logic               busWrEn,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  input  logic               wrapPulse,
  output dpStrobe_t          strobe,
  output logic [SEL_W-1:0]   expSel,
  output logic [PHASE_W-1:0] period,
  output logic [PHASE_W-1:0] duty,
  output logic               irqOut
);
  localparam logic [SEL_W-1:0]  MAX_SEL = SEL_W'(MAX_EXP);
  localparam logic [STOP_W-1:0] ONE     = STOP_W'(1);

  logic [CTRL_W-1:0]  ctrlReg;
  logic [PHASE_W-1:0] periodReg;
  logic [PHASE_W-1:0] dutyReg;
  logic [STOP_W-1:0]  countReg;
  logic [STOP_W-1:0]  remain;
  logic               irqFlag;
  logic wrCtrl, wrPeriod, wrDuty, wrCount, stopNow;

  assign wrCtrl   = busWrEn && (regIdx_e'(busAddr) == REG_CTRL);
  assign wrPeriod = busWrEn && (regIdx_e'(busAddr) == REG_PERIOD);
  assign wrDuty   = busWrEn && (regIdx_e'(busAddr) == REG_DUTY);
  assign wrCount  = busWrEn && (regIdx_e'(busAddr) == REG_COUNT);

  // Final period of an auto-stop run; a write in the same cycle wins
  assign stopNow = wrapPulse && ctrlReg[RUN_BIT] && ctrlReg[STOP_BIT]
                   && (remain <= ONE) && !busWrEn;

  assign expSel = (ctrlReg[SEL_W-1:0] > MAX_SEL) ? MAX_SEL : ctrlReg[SEL_W-1:0];
  assign period = periodReg;
  assign duty   = dutyReg;
  assign strobe.restart = busWrEn;
  assign strobe.run     = ctrlReg[RUN_BIT];
  assign irqOut = irqFlag && !ctrlReg[MASK_BIT];

  always_comb begin
    unique case (regIdx_e'(busAddr))
      REG_CTRL:   busRdData = DATA_W'(ctrlReg);
      REG_PERIOD: busRdData = DATA_W'(periodReg);
      REG_DUTY:   busRdData = DATA_W'(dutyReg);
      REG_COUNT:  busRdData = DATA_W'(countReg);
      default:    busRdData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      periodReg <= '0;
      dutyReg   <= '0;
      countReg  <= '0;
      remain    <= '0;
      irqFlag   <= 1'b0;
    end else begin
      if (wrCtrl)       ctrlReg <= busWrData[CTRL_W-1:0];
      else if (stopNow) ctrlReg[RUN_BIT] <= 1'b0;

      if (wrPeriod) periodReg <= busWrData[PHASE_W-1:0];
      if (wrDuty)   dutyReg   <= busWrData[PHASE_W-1:0];
      if (wrCount)  countReg  <= busWrData[STOP_W-1:0];

      if (busWrEn)
        remain <= wrCount ? busWrData[STOP_W-1:0] : countReg;
      else if (wrapPulse && ctrlReg[STOP_BIT])
        remain <= (remain <= ONE) ? '0 : remain - ONE;

      if (wrCtrl)       irqFlag <= 1'b0;
      else if (stopNow) irqFlag <= 1'b1;
    end
  end

  // R9
  autostop_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrapPulse && ctrlReg[STOP_BIT] && ctrlReg[RUN_BIT] && (remain == ONE) && !busWrEn)
      |=> !ctrlReg[RUN_BIT]);

  // R10
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> ($past(ctrlReg[RUN_BIT]) && !ctrlReg[RUN_BIT]));

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !wrCtrl) |=> irqFlag);
endmodule

// File: rtl/led_blinker.sv
module led_blinker
  import blink_pkg::*;
#(
  parameter int PHASE_W = 12,
  parameter int STOP_W  = 16,
  parameter int DATA_W  = 16,
  parameter int MAX_EXP = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              ledOut,
  output logic              irqOut
);
  dpStrobe_t          strobe;
  logic [SEL_W-1:0]   expSel;
  logic [PHASE_W-1:0] period;
  logic [PHASE_W-1:0] duty;
  logic               wrapPulse;

  blink_ctrl #(
    .PHASE_W(PHASE_W), .STOP_W(STOP_W), .DATA_W(DATA_W), .MAX_EXP(MAX_EXP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .wrapPulse(wrapPulse),
    .strobe(strobe), .expSel(expSel), .period(period), .duty(duty),
    .irqOut(irqOut)
  );

  blink_dp #(
    .PHASE_W(PHASE_W), .MAX_EXP(MAX_EXP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .expSel(expSel),
    .period(period), .duty(duty), .wrapPulse(wrapPulse), .ledOut(ledOut)
  );
endmodule

// File: tb/led_blinker_bench.sv
`timescale 1ns/1ps
module led_blinker_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = 16'd0;
  logic [15:0] busRdData;
  logic        ledOut, irqOut;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  led_blinker u_led_blinker (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .ledOut(ledOut), .irqOut(irqOut)
  );

  // period / duty pairs walked with exponent 13
  localparam int NV = 8;
  localparam int VP[NV] = '{4, 5, 3, 6, 2, 0, 3, 1};
  localparam int VD[NV] = '{2, 1, 3, 0, 1, 1, 5, 0};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a);
    busAddr = a;
    #0.5;
  endtask

  function automatic int expLed(input int k, input int n, input int p, input int d);
    int per, ph;
    per = 1 << (13 - n);
    ph  = (p <= 1) ? 0 : (k / per) % p;
    return (ph < d) ? 1 : 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R1: reset state
    check("R1 led", ledOut, 0);
    check("R1 irq", irqOut, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a));
      check("R1 readback", busRdData, 0);
    end

    // R2: widths and readback
    wr(2'd1, 16'hFFFF); rd(2'd1); check("R2 period", busRdData, 16'h0FFF);
    wr(2'd2, 16'hABCD); rd(2'd2); check("R2 duty", busRdData, 16'h0BCD);
    wr(2'd3, 16'hBEEF); rd(2'd3); check("R2 count", busRdData, 16'hBEEF);
    wr(2'd0, 16'hFF80); rd(2'd0); check("R2 ctrl", busRdData, 16'h0000);
    wr(2'd0, 16'h00FF); rd(2'd0); check("R2 ctrl bits", busRdData, 16'h007F);
    wr(2'd0, 16'h0000);

    // R5 R6: vector walk, exponent 13
    for (int v = 0; v < NV; v++) begin
      wr(2'd1, 16'(VP[v]));
      wr(2'd2, 16'(VD[v]));
      wr(2'd0, 16'h001D);
      for (int k = 0; k < 12; k++) begin
        check("R5 R6 vector", ledOut, expLed(k, 13, VP[v], VD[v]));
        step(1);
      end
    end

    // R3: exponent 11 -> 4 cycles per tick
    wr(2'd1, 16'd2); wr(2'd2, 16'd1); wr(2'd0, 16'h001B);
    for (int k = 0; k < 16; k++) begin
      check("R3 divider", ledOut, expLed(k, 11, 2, 1));
      step(1);
    end
    // R3: exponent 10 -> 8 cycles per tick
    wr(2'd0, 16'h001A);
    for (int k = 0; k < 24; k++) begin
      check("R3 divider 10", ledOut, expLed(k, 10, 2, 1));
      step(1);
    end

    // R4: exponent 15 clamps to 13
    wr(2'd0, 16'h001F);
    rd(2'd0); check("R4 readback", busRdData, 16'h001F);
    for (int k = 0; k < 6; k++) begin
      check("R4 clamp", ledOut, expLed(k, 13, 2, 1));
      step(1);
    end

    // R7: disabled keeps LED dark
    wr(2'd1, 16'd4); wr(2'd2, 16'd4); wr(2'd0, 16'h000D);
    step(3);
    check("R7 disabled", ledOut, 0);

    // R8: mid-period write restarts at phase 0
    wr(2'd2, 16'd2); wr(2'd0, 16'h001D);
    wr(2'd2, 16'd2);
    check("R8 restart k0", ledOut, 1);
    step(1); check("R8 restart k1", ledOut, 1);
    step(1); check("R8 restart k2", ledOut, 0);

    // R9 R10: auto-stop after 3 periods, unmasked
    wr(2'd1, 16'd2); wr(2'd2, 16'd1); wr(2'd3, 16'd3); wr(2'd0, 16'h003D);
    step(4); check("R9 running k4", ledOut, 1);
    step(1); check("R10 no irq yet", irqOut, 0);
    step(1); check("R9 stopped", ledOut, 0);
    check("R10 irq", irqOut, 1);
    rd(2'd0); check("R9 run bit cleared", busRdData, 16'h002D);
    step(10); check("R9 stays off", ledOut, 0);
    check("R10 sticky", irqOut, 1);
    wr(2'd1, 16'd2);
    check("R10 other write keeps", irqOut, 1);
    wr(2'd0, 16'h0000);
    check("R10 ctrl write clears", irqOut, 0);

    // R10: masked stop
    wr(2'd0, 16'h007D);
    step(6); check("R9 masked stop", ledOut, 0);
    check("R10 masked irq", irqOut, 0);
    rd(2'd0); check("R10 masked readback", busRdData, 16'h006D);

    // R9: count 0 acts as 1
    wr(2'd3, 16'd0); wr(2'd0, 16'h003D);
    step(2); check("R9 count0 stop", ledOut, 0);
    check("R9 count0 irq", irqOut, 1);
    wr(2'd0, 16'h0000);

    // R11: auto-stop disabled runs on
    wr(2'd3, 16'd1); wr(2'd0, 16'h001D);
    step(20); check("R11 still on", ledOut, 1);
    step(1);  check("R11 still off phase", ledOut, 0);
    check("R11 no irq", irqOut, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule